// File: doc/BRIEF.md
# Global Restart-Cause and Clock-Mode Status Register

This block is a single 8-bit control and status register on a simple I/O bus. A read returns why the chip last restarted: either a reset, or a watchdog timeout. The read also clears that cause, so software can tell a fresh event from one it has already seen. The same byte carries two writable fields. One is a 3-bit clock-mode selector that is handed to the clock generator. The other is a 2-bit priority for the periodic interrupt, where zero turns the interrupt off.

Bit 5 is a write-only command. Writing a one there forces a periodic interrupt to become pending, and the bit always reads back as zero. The pending flag goes out to the interrupt controller and drops when that controller acknowledges it.

The restart cause is tracked by a small state machine with three states. CAUSE_RST is entered on reset. CAUSE_WDOG is entered from any state when a watchdog timeout pulse arrives. CAUSE_NONE is entered from CAUSE_RST or CAUSE_WDOG on a read of the register that has no timeout in the same cycle. Any other cycle holds the state.

The pending flag is a second state machine with two states. PEND_ARMED is entered from PEND_IDLE on a force write while the resulting priority is nonzero. PEND_IDLE is entered from PEND_ARMED on an acknowledge without a force write, or whenever the resulting priority is 00.

Top module: `gstat_reg`

## Requirements
- R1: During and after reset the register reads 0xC0: cause 11, clock mode 000, priority 00, and the pending flag is 0.
- R2: A read at the register address returns the restart cause in bits 7:6: 11 after reset, 01 after a watchdog timeout, 00 once cleared. The value 10 never appears.
- R3: A read at the register address returns the cause in that cycle and clears the cause to 00 from the next cycle on.
- R4: A watchdog timeout pulse sets the cause to 01 in the next cycle. This holds even when a clearing read happens in the same cycle, and even when the cause was 11.
- R5: A write at the register address loads bits 4:2 into the clock mode and bits 1:0 into the priority, visible on the outputs after the clock edge. Writes never change bits 7:6.
- R6: Bit 5 of the read data is always 0.
- R7: A write with bit 5 = 1 sets the pending flag in the next cycle, as long as the priority written in that same write is nonzero.
- R8: The acknowledge input clears the pending flag in the next cycle. A force write in the same cycle wins, and the flag stays set.
- R9: While the priority is 00 the pending flag is held at 0. Writing priority 00 clears a flag that is set, and a force write that carries priority 00 does not set it.
- R10: An access at any other address changes no state and reads as 0x00. In particular, it does not clear the cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | I/O bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| wdog_tmo | input | 1 | Watchdog timeout pulse |
| irq_ack | input | 1 | Periodic interrupt acknowledge |
| rd_data | output | 8 | Read data, combinational during a read hit, else 0 |
| clk_mode | output | 3 | Clock-mode field |
| irq_prio | output | 2 | Periodic interrupt priority, 00 = disabled |
| irq_pend | output | 1 | Periodic interrupt pending |

## Verification
The bench builds the block with its defaults: a 16-bit address and the register at address 0x0000. The neighbouring addresses 0x0001, 0x0004 and 0x0005 are used as near misses. With these values a one-bit address slip on a read or a write shows up as a wrong clear or a wrong field load.

The table walks the cause state machine through all three states. It includes the timeout that coincides with a clearing read, and force writes combined with acknowledges and with priority 00. Directed steps then apply a reset in the middle of the run and check that a timeout overrides the reset cause.

// File: rtl/gstat_pkg.sv
package gstat_pkg;

    localparam int DATA_W    = 8;
    localparam int MODE_W    = 3;
    localparam int PRIO_W    = 2;
    localparam int CAUSE_LSB = 6;
    localparam int FORCE_BIT = 5;
    localparam int MODE_LSB  = 2;
    localparam int PRIO_LSB  = 0;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_WDOG = 2'b01,
        CAUSE_RST  = 2'b11
    } cause_e;

    typedef enum logic {
        PEND_IDLE  = 1'b0,
        PEND_ARMED = 1'b1
    } pend_e;

endpackage

// File: rtl/gstat_bus_dec.sv
module gstat_bus_dec #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              rd_hit,
    output logic              wr_hit
);

    logic addr_match;

    always_comb begin
        addr_match = (bus_addr == REG_ADDR);
        rd_hit     = bus_rd & addr_match;
        wr_hit     = bus_wr & addr_match;
    end

endmodule

// File: rtl/gstat_cause_fsm.sv
module gstat_cause_fsm
    import gstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_hit,
    input  logic       wdog_tmo,
    output logic [1:0] cause
);

    cause_e state_q;
    cause_e state_d;

    // State register: reset records CAUSE_RST.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAUSE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: the timeout has priority over a clearing read.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAUSE_RST: begin
                if (wdog_tmo)    state_d = CAUSE_WDOG;
                else if (rd_hit) state_d = CAUSE_NONE;
            end
            CAUSE_WDOG: begin
                if (wdog_tmo)    state_d = CAUSE_WDOG;
                else if (rd_hit) state_d = CAUSE_NONE;
            end
            CAUSE_NONE: begin
                if (wdog_tmo)    state_d = CAUSE_WDOG;
            end
            default: state_d = CAUSE_RST;
        endcase
    end

    // Outputs: the state encoding is the read-back code of bits 7:6.
    always_comb begin
        cause = 2'b00;
        unique case (state_q)
            CAUSE_RST:  cause = 2'b11;
            CAUSE_WDOG: cause = 2'b01;
            CAUSE_NONE: cause = 2'b00;
            default:    cause = 2'b00;
        endcase
    end

endmodule

// File: rtl/gstat_ctrl_fields.sv
module gstat_ctrl_fields
    import gstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [PRIO_W-1:0] wr_prio,
    output logic [MODE_W-1:0] mode_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [PRIO_W-1:0] prio_nxt
);

    always_comb begin
        prio_nxt = wr_hit ? wr_prio : prio_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            prio_q <= '0;
        end else if (wr_hit) begin
            mode_q <= wr_mode;
            prio_q <= wr_prio;
        end
    end

endmodule

// File: rtl/gstat_pend_fsm.sv
module gstat_pend_fsm
    import gstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_req,
    input  logic              ack,
    input  logic [PRIO_W-1:0] prio_nxt,
    output logic              pend
);

    pend_e state_q;
    pend_e state_d;
    logic  prio_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PEND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        prio_off = (prio_nxt == '0);
        state_d  = state_q;
        unique case (state_q)
            PEND_IDLE: begin
                if (force_req && !prio_off) state_d = PEND_ARMED;
            end
            PEND_ARMED: begin
                if (prio_off)                state_d = PEND_IDLE;
                else if (ack && !force_req)  state_d = PEND_IDLE;
            end
            default: state_d = PEND_IDLE;
        endcase
    end

    always_comb begin
        pend = 1'b0;
        unique case (state_q)
            PEND_IDLE:  pend = 1'b0;
            PEND_ARMED: pend = 1'b1;
            default:    pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/gstat_reg.sv
module gstat_reg
    import gstat_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              wdog_tmo,
    input  logic              irq_ack,
    output logic [7:0]        rd_data,
    output logic [2:0]        clk_mode,
    output logic [1:0]        irq_prio,
    output logic              irq_pend
);

    logic              rd_hit;
    logic              wr_hit;
    logic [1:0]        cause_q;
    logic [MODE_W-1:0] mode_q;
    logic [PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0] prio_nxt;
    logic              force_req;
    logic              pend_q;

    gstat_bus_dec #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    gstat_cause_fsm u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .wdog_tmo (wdog_tmo),
        .cause    (cause_q)
    );

    gstat_ctrl_fields u_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wr_mode  (bus_wdata[MODE_LSB +: MODE_W]),
        .wr_prio  (bus_wdata[PRIO_LSB +: PRIO_W]),
        .mode_q   (mode_q),
        .prio_q   (prio_q),
        .prio_nxt (prio_nxt)
    );

    always_comb begin
        force_req = wr_hit & bus_wdata[FORCE_BIT];
    end

    gstat_pend_fsm u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_req (force_req),
        .ack       (irq_ack),
        .prio_nxt  (prio_nxt),
        .pend      (pend_q)
    );

    // Read mux: the command bit position is always returned as zero.
    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            rd_data[CAUSE_LSB +: 2]      = cause_q;
            rd_data[FORCE_BIT]           = 1'b0;
            rd_data[MODE_LSB +: MODE_W]  = mode_q;
            rd_data[PRIO_LSB +: PRIO_W]  = prio_q;
        end
        clk_mode = mode_q;
        irq_prio = prio_q;
        irq_pend = pend_q;
    end

endmodule

// File: rtl/gstat_chk.sv
module gstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_hit,
    input logic       wr_hit,
    input logic [7:0] wdata,
    input logic       wdog,
    input logic       ack,
    input logic [7:0] rd_data,
    input logic [1:0] cause_q,
    input logic [2:0] mode,
    input logic [1:0] prio,
    input logic       pend
);

    assert_cause_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q != 2'b10);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && !wdog |=> cause_q == 2'b00);

    assert_wdog_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdog |=> cause_q == 2'b01);

    assert_write_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (mode == $past(wdata[4:2])) && (prio == $past(wdata[1:0])));

    assert_cause_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && (wdata[7:6] != 2'b00) && !rd_hit && !wdog |=> cause_q == $past(cause_q));

    assert_force_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] == 1'b0);

    assert_force_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && wdata[5] && (wdata[1:0] != 2'b00) |=> pend);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !(wr_hit && wdata[5]) |=> !pend);

    assert_prio_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prio == 2'b00 |-> !pend);

    assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> rd_data == 8'h00);

endmodule

bind gstat_reg gstat_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit),
    .wdata   (bus_wdata),
    .wdog    (wdog_tmo),
    .ack     (irq_ack),
    .rd_data (rd_data),
    .cause_q (cause_q),
    .mode    (clk_mode),
    .prio    (irq_prio),
    .pend    (irq_pend)
);

// File: tb/gstat_reg_tb.sv
`timescale 1ns/1ps
module gstat_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        wdog_tmo = 1'b0;
    logic        irq_ack = 1'b0;
    logic [7:0]  rd_data;
    logic [2:0]  clk_mode;
    logic [1:0]  irq_prio;
    logic        irq_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gstat_reg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .wdog_tmo  (wdog_tmo),
        .irq_ack   (irq_ack),
        .rd_data   (rd_data),
        .clk_mode  (clk_mode),
        .irq_prio  (irq_prio),
        .irq_pend  (irq_pend)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        rd;
        logic        wr;
        logic [7:0]  wdata;
        logic        wdog;
        logic        ack;
        logic [7:0]  exp_rd;
        logic [2:0]  exp_mode;
        logic [1:0]  exp_prio;
        logic        exp_pend;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hC0, 3'd0, 2'd0, 1'b0, 4'd2},  // R2 reset cause
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0, 4'd3},  // R3 cleared
        '{16'h0000, 1'b0, 1'b1, 8'h1D, 1'b0, 1'b0, 8'h00, 3'd7, 2'd1, 1'b0, 4'd5},  // R5 write
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h1D, 3'd7, 2'd1, 1'b0, 4'd5},  // R5 read back
        '{16'h0000, 1'b0, 1'b1, 8'hFE, 1'b0, 1'b0, 8'h00, 3'd7, 2'd2, 1'b1, 4'd7},  // R7 force
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h1E, 3'd7, 2'd2, 1'b1, 4'd6},  // R6, R5 bits 7:6
        '{16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 3'd7, 2'd2, 1'b1, 4'd4},  // R4 timeout
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h5E, 3'd7, 2'd2, 1'b1, 4'd4},  // R4 read + timeout
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h5E, 3'd7, 2'd2, 1'b1, 4'd4},  // R4 timeout won
        '{16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h1E, 3'd7, 2'd2, 1'b1, 4'd3},  // R3
        '{16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 3'd7, 2'd2, 1'b0, 4'd8},  // R8 ack
        '{16'h0000, 1'b0, 1'b1, 8'h29, 1'b0, 1'b1, 8'h00, 3'd2, 2'd1, 1'b1, 4'd8},  // R8 force wins
        '{16'h0004, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0, 8'h00, 3'd2, 2'd1, 1'b1, 4'd10}, // R10 miss write
        '{16'h0004, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'd2, 2'd1, 1'b1, 4'd10}, // R10 miss read
        '{16'h0000, 1'b0, 1'b1, 8'h20, 1'b0, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0, 4'd9},  // R9 clears
        '{16'h0000, 1'b0, 1'b1, 8'h2C, 1'b0, 1'b0, 8'h00, 3'd3, 2'd0, 1'b0, 4'd9}   // R9 no set
    };

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check read data before the rising edge,
    // check registered outputs just after it.
    task automatic step(input string tag, input logic [15:0] a, input logic r,
                        input logic w, input logic [7:0] d, input logic wd,
                        input logic ak, input logic [7:0] erd, input logic [2:0] em,
                        input logic [1:0] ep, input logic en);
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        wdog_tmo = wd; irq_ack = ak;
        #1;
        check(tag, "rd_data", rd_data, erd);
        @(posedge clk);
        #1;
        bus_rd = 1'b0; bus_wr = 1'b0; wdog_tmo = 1'b0; irq_ack = 1'b0;
        check(tag, "clk_mode", {5'd0, clk_mode}, {5'd0, em});
        check(tag, "irq_prio", {6'd0, irq_prio}, {6'd0, ep});
        check(tag, "irq_pend", {7'd0, irq_pend}, {7'd0, en});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state visible while reset is held
        bus_addr = 16'h0000; bus_rd = 1'b1;
        #1;
        check("R1", "rd_data in reset", rd_data, 8'hC0);
        check("R1", "irq_pend in reset", {7'd0, irq_pend}, 8'h00);
        bus_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].rd,
                 VECS[i].wr, VECS[i].wdata, VECS[i].wdog, VECS[i].ack, VECS[i].exp_rd,
                 VECS[i].exp_mode, VECS[i].exp_prio, VECS[i].exp_pend);
        end

        // R1: reset in the middle of the run restores every field
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "clk_mode after reset", {5'd0, clk_mode}, 8'h00);
        check("R1", "irq_prio after reset", {6'd0, irq_prio}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: a read elsewhere neither returns data nor clears the cause
        step("R10", 16'h0005, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0);
        step("R10", 16'h0001, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0);
        step("R2",  16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'hC0, 3'd0, 2'd0, 1'b0);
        // R4: a timeout replaces the reset cause before any read
        step("R4",  16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step("R4",  16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0);
        step("R4",  16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h40, 3'd0, 2'd0, 1'b0);
        // R7: force with a nonzero priority in the same write
        step("R7",  16'h0000, 1'b0, 1'b1, 8'h27, 1'b0, 1'b0, 8'h00, 3'd1, 2'd3, 1'b1);
        step("R3",  16'h0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h07, 3'd1, 2'd3, 1'b1);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule